// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block forms the two's complement (arithmetic negation, modulo 2^W) of a W-bit word one bit at a time. A shift register is parallel-loaded with the operand. Its least significant bit is then inspected on every step, and the controller pushes a computed bit into the most significant end while the register moves right. A bit counter tracks how many bits have been processed. A done flag rises once every operand bit has been replaced, and the register then holds the negated word.

The controller is a Moore machine. Every control strobe (serial bit, shift, load, counter increment, counter clear, done set, done clear) is a function of the current state only, so every inspection of the low bit and every shift takes one cycle each. A conversion starts when the asynchronous reset is released. It ends in a holding state that keeps the result until the next reset.

States: `ST_LOAD` (load operand, clear counter and done), `ST_SEEK` (inspect the low bit, no 1 seen yet), `ST_PUT0_SEEK` (shift in 0, return to seek), `ST_PUT1` (shift in 1, then go to flip), `ST_FLIP` (inspect the low bit after the first 1), `ST_PUT0_FLIP` (shift in 0, return to flip), `ST_FIN` (set done), `ST_HOLD` (idle with the result). Transitions:
- `ST_LOAD` always goes to `ST_SEEK`.
- `ST_SEEK` goes to `ST_FIN` when the counter equals W. Otherwise it goes to `ST_PUT1` on a low bit of 1 and to `ST_PUT0_SEEK` on a low bit of 0.
- `ST_PUT0_SEEK` goes back to `ST_SEEK`.
- `ST_FLIP` goes to `ST_FIN` when the counter equals W. Otherwise it goes to `ST_PUT0_FLIP` on a low bit of 1 and to `ST_PUT1` on a low bit of 0.
- `ST_PUT1` and `ST_PUT0_FLIP` both go back to `ST_FLIP`.
- `ST_FIN` goes to `ST_HOLD`, and `ST_HOLD` stays where it is.

Top module: `serial_negator`

## Requirements
- R1: While `arst` is high, `result`, `bit_count` and `done` are 0 at once, without waiting for a clock edge.
- R2: On the first rising edge after `arst` falls, `result` takes `din`, and `bit_count` and `done` are 0.
- R3: Each processed bit takes two cycles: one to inspect, then one to shift. `bit_count` rises by exactly 1 on each shift edge and never exceeds W. After edge 2k+1 following reset release, `bit_count` equals k.
- R4: Each shift moves `result` right by one and inserts a new MSB. That MSB equals the inspected LSB up to and including the first 1. After that it equals the inverted LSB. At most one of load, shift and done-set is active in any cycle.
- R5: `done` rises on the 19th rising edge after reset release (for W = 8), and `bit_count` equals W whenever `done` is 1.
- R6: When `done` rises, `result` equals (2^W − din) mod 2^W for the loaded `din`. In particular 0x00 gives 0x00 and 0x80 gives 0x80.
- R7: Once `done` is 1, `result`, `bit_count` and `done` hold their values on every later edge until reset, whatever `din` does.
- R8: Changes of `din` after the load edge have no effect on the result.
- R9: Asserting `arst` in the middle of a conversion abandons it. The next release starts a fresh conversion of the current `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous active-high reset; its release starts a conversion |
| din | input | W (8) | Operand, captured on the first edge after reset release |
| result | output | W (8) | Shift register contents; the negated operand once `done` is 1 |
| bit_count | output | $clog2(W+1) (4) | Number of bits shifted so far |
| done | output | 1 | Conversion complete flag |

## Verification
The assertions assume that `din` is held steady up to the load edge, since the checker's reference copy is taken from `din` at that edge. They also assume that `arst` changes away from the rising clock edge. The bench drives `din` and `arst` only on falling edges and sets each operand before releasing reset. It changes `din` only after the load edge, when a test deliberately checks that later changes are ignored. Mid-conversion resets are also asserted on a falling edge, so each restart begins from a clean load.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [2:0] {
        ST_LOAD      = 3'd0,
        ST_SEEK      = 3'd1,
        ST_PUT0_SEEK = 3'd2,
        ST_PUT1      = 3'd3,
        ST_FLIP      = 3'd4,
        ST_PUT0_FLIP = 3'd5,
        ST_FIN       = 3'd6,
        ST_HOLD      = 3'd7
    } tc_state_e;

    typedef struct packed {
        logic d;
        logic shift;
        logic load;
        logic inc;
        logic clr;
        logic set_done;
        logic clr_done;
    } tc_ctl_s;

    localparam tc_ctl_s CTL_IDLE = '{default: 1'b0};

endpackage

// File: rtl/tc_shreg.sv
module tc_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         arst,
    input  logic         load,
    input  logic         shift,
    input  logic         d,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= {d, q[W-1:1]};
        end
    end

endmodule

// File: rtl/tc_bitcount.sv
module tc_bitcount #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          at_end
);

    localparam logic [CW-1:0] LAST = CW'(W);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != LAST) begin
            count <= count + CW'(1);
        end
    end

    assign at_end = (count == LAST);

endmodule

// File: rtl/tc_doneflag.sv
module tc_doneflag (
    input  logic clk,
    input  logic arst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end
    end

endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
    import tc_pkg::*;
(
    input  logic    clk,
    input  logic    arst,
    input  logic    lsb,
    input  logic    at_end,
    output tc_ctl_s ctl
);

    tc_state_e state;
    tc_state_e state_nx;

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:      state_nx = ST_SEEK;
            ST_SEEK: begin
                if (at_end)   state_nx = ST_FIN;
                else if (lsb) state_nx = ST_PUT1;
                else          state_nx = ST_PUT0_SEEK;
            end
            ST_PUT0_SEEK: state_nx = ST_SEEK;
            ST_PUT1:      state_nx = ST_FLIP;
            ST_FLIP: begin
                if (at_end)   state_nx = ST_FIN;
                else if (lsb) state_nx = ST_PUT0_FLIP;
                else          state_nx = ST_PUT1;
            end
            ST_PUT0_FLIP: state_nx = ST_FLIP;
            ST_FIN:       state_nx = ST_HOLD;
            ST_HOLD:      state_nx = ST_HOLD;
            default:      state_nx = ST_LOAD;
        endcase
    end

    // Moore outputs: a function of state only
    always_comb begin
        ctl = CTL_IDLE;
        unique case (state)
            ST_LOAD: begin
                ctl.load     = 1'b1;
                ctl.clr      = 1'b1;
                ctl.clr_done = 1'b1;
            end
            ST_PUT0_SEEK, ST_PUT0_FLIP: begin
                ctl.d     = 1'b0;
                ctl.shift = 1'b1;
                ctl.inc   = 1'b1;
            end
            ST_PUT1: begin
                ctl.d     = 1'b1;
                ctl.shift = 1'b1;
                ctl.inc   = 1'b1;
            end
            ST_FIN:   ctl.set_done = 1'b1;
            ST_SEEK, ST_FLIP, ST_HOLD: ctl = CTL_IDLE;
            default:  ctl = CTL_IDLE;
        endcase
    end

endmodule

// File: rtl/serial_negator.sv
module serial_negator
    import tc_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          arst,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  result,
    output logic [CW-1:0] bit_count,
    output logic          done
);

    tc_ctl_s ctl;
    logic    at_end;

    tc_ctrl u_ctrl (
        .clk    (clk),
        .arst   (arst),
        .lsb    (result[0]),
        .at_end (at_end),
        .ctl    (ctl)
    );

    tc_shreg #(.W(W)) u_shreg (
        .clk   (clk),
        .arst  (arst),
        .load  (ctl.load),
        .shift (ctl.shift),
        .d     (ctl.d),
        .din   (din),
        .q     (result)
    );

    tc_bitcount #(.W(W), .CW(CW)) u_count (
        .clk    (clk),
        .arst   (arst),
        .clr    (ctl.clr),
        .inc    (ctl.inc),
        .count  (bit_count),
        .at_end (at_end)
    );

    tc_doneflag u_done (
        .clk  (clk),
        .arst (arst),
        .set  (ctl.set_done),
        .clr  (ctl.clr_done),
        .q    (done)
    );

endmodule

// File: rtl/serial_negator_chk.sv
module serial_negator_chk #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          arst,
    input logic [W-1:0]  din,
    input logic [W-1:0]  result,
    input logic [CW-1:0] bit_count,
    input logic          done,
    input logic          load,
    input logic          shift,
    input logic          set_done
);

    logic [W-1:0] ref_word;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            ref_word <= '0;
        end else if (load) begin
            ref_word <= din;
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (arst)
        bit_count <= CW'(W));

    p_shift_step_r3: assert property (@(posedge clk) disable iff (arst)
        shift |=> bit_count == $past(bit_count) + CW'(1));

    p_one_action_r4: assert property (@(posedge clk) disable iff (arst)
        $onehot0({load, shift, set_done}));

    p_done_count_r5: assert property (@(posedge clk) disable iff (arst)
        done |-> bit_count == CW'(W));

    p_result_r6: assert property (@(posedge clk) disable iff (arst)
        $rose(done) |-> result == W'(~ref_word + W'(1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (arst)
        done |=> (done && $stable(result) && $stable(bit_count)));

endmodule

bind serial_negator serial_negator_chk #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .arst      (arst),
    .din       (din),
    .result    (result),
    .bit_count (bit_count),
    .done      (done),
    .load      (ctl.load),
    .shift     (ctl.shift),
    .set_done  (ctl.set_done)
);

// File: tb/serial_negator_bench.sv
module serial_negator_bench;

    localparam int W          = 8;
    localparam int CW         = 4;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 19;

    logic          clk = 1'b0;
    logic          arst = 1'b1;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  result;
    logic [CW-1:0] bit_count;
    logic          done;

    int checks = 0;
    int fails  = 0;

    serial_negator #(.W(W)) u_serial_negator (
        .clk       (clk),
        .arst      (arst),
        .din       (din),
        .result    (result),
        .bit_count (bit_count),
        .done      (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] neg(input logic [W-1:0] v);
        return W'(~v + W'(1));
    endfunction

    // Apply reset on a falling edge; the next rising edge is the load edge
    task automatic restart(input logic [W-1:0] v);
        @(negedge clk);
        arst = 1'b1;
        din  = v;
        @(negedge clk);
        arst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Returns the edge count at which done was first seen
    task automatic wait_done(output int n);
        n = 0;
        for (int i = 1; i <= 40; i++) begin
            edges(1);
            if (done) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset_state;
        restart(8'h5A);
        edges(6);
        @(negedge clk);
        #1 arst = 1'b1;
        #1;
        chk("R1 result", result, 0);
        chk("R1 count", bit_count, 0);
        chk("R1 done", done, 0);
        @(negedge clk);
        arst = 1'b0;
    endtask

    task automatic t_step_trace;
        restart(8'h06);
        edges(1);
        chk("R2 load result", result, 8'h06);
        chk("R2 load count", bit_count, 0);
        chk("R2 load done", done, 0);
        edges(1);
        chk("R3 inspect keeps result", result, 8'h06);
        chk("R3 inspect keeps count", bit_count, 0);
        edges(1);
        chk("R4 zero copied", result, 8'h03);
        chk("R3 count after shift1", bit_count, 1);
        edges(2);
        chk("R4 first one copied", result, 8'h81);
        chk("R3 count after shift2", bit_count, 2);
        edges(2);
        chk("R4 later one inverted", result, 8'h40);
        chk("R3 count after shift3", bit_count, 3);
    endtask

    task automatic t_all_values;
        for (int v = 0; v < 256; v++) begin
            int n;
            restart(W'(v));
            wait_done(n);
            chk("R5 latency", n, LATENCY);
            chk("R5 count at done", bit_count, W);
            chk("R6 negation", result, neg(W'(v)));
        end
    endtask

    task automatic t_hold;
        int n;
        restart(8'h80);
        wait_done(n);
        chk("R6 0x80 maps to itself", result, 8'h80);
        din = 8'h13;
        edges(10);
        chk("R7 result held", result, 8'h80);
        chk("R7 count held", bit_count, W);
        chk("R7 done held", done, 1);
    endtask

    task automatic t_din_ignored;
        int n;
        restart(8'h35);
        edges(1);
        din = 8'hFF;
        wait_done(n);
        chk("R8 late din ignored", result, 8'hCB);
    endtask

    task automatic t_abort;
        int n;
        restart(8'h01);
        edges(7);
        @(negedge clk);
        arst = 1'b1;
        din  = 8'h7F;
        @(negedge clk);
        arst = 1'b0;
        wait_done(n);
        chk("R9 restart latency", n, LATENCY);
        chk("R9 restart result", result, 8'h81);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1;
        chk("R1 initial result", result, 0);
        chk("R1 initial done", done, 0);
        t_reset_state();
        t_step_trace();
        t_all_values();
        t_hold();
        t_din_ignored();
        t_abort();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule